// File: doc/BRIEF.md
# Pause-Width Bit Modulator

This block frames and sends reader-to-card bits on a contactless link. It sends each bit as a fixed carrier-off gap followed by a carrier-on stretch, and the total length of the bit tells a one from a zero. A frame of up to 32 bits is loaded with its bit count and a start strobe. The bits go out lowest first, and each one is XORed with a keystream bit taken from an external scrambler port. After the last data bit the block adds one more carrier-off gap, then returns the carrier to on.

Time is kept by a free-running tick counter that advances on a tick enable (1.5 ticks per microsecond in normal use). The block also holds a shared end-of-frame timestamp. It rewrites that timestamp when its own frame ends or when a receive block reports the end of a received frame. A new frame may not begin until a fixed guard interval has passed since that timestamp. A receive path can read the same timestamp to schedule its own sampling window.

Top module: `pause_bit_modulator`

## Requirements
- R1: After reset `mod_o` is 1, `busy_o` and `done_o` are 0, and `now_o` and `last_end_o` are 0. Whenever `busy_o` is 0, `mod_o` is 1 (carrier on).
- R2: `now_o` rises by one (modulo 2^16) on each clock edge where `tick_i` is 1, and holds on other edges.
- R3: The first carrier-off gap of a frame begins (first sample with `mod_o`=0) with `now_o` equal to `last_end_o`+330. If that count is already reached, it begins two clocks after the clock in which `start_i` is taken.
- R4: Every per-bit carrier-off gap lasts exactly 30 ticks.
- R5: A transmitted 1 lasts 150 ticks and a transmitted 0 lasts 90 ticks, gap included (carrier on for 120 or 60 ticks).
- R6: Bits are sent from bit 0 of `frame_i` upward, and `len_i` of them are sent. `frame_i` and `len_i` are captured with `start_i`.
- R7: The transmitted bit is the data bit XOR `ks_bit_i`, sampled in the clock where `ks_adv_o` is 1. `ks_adv_o` pulses exactly once per data bit, and only while the block is busy and the carrier is on.
- R8: After the last data bit a closing 30-tick carrier-off gap is sent, then `mod_o` returns to 1. With `len_i`=0 only this closing gap is sent.
- R9: `done_o` is 1 for exactly one clock: the first clock after the closing gap, in which `mod_o` is 1 again and `busy_o` is 0.
- R10: `start_i` is ignored while `busy_o` is 1. It neither alters the frame in flight nor causes a further frame.
- R11: At the end of each frame, and on each clock with `rx_end_i`=1, `last_end_o` takes the tick count after that clock edge. It is otherwise unchanged.
- R12: Every length from 0 to 32 is sent correctly, including 6, 7 and 23 bits. Length codes above 32 send 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick enable for the time counter |
| start_i | input | 1 | Start strobe, taken when idle |
| frame_i | input | 32 | Frame data, bit 0 sent first |
| len_i | input | 6 | Number of bits to send |
| ks_bit_i | input | 1 | Current keystream bit |
| rx_end_i | input | 1 | End of a received frame, stamps the timestamp |
| ks_adv_o | output | 1 | Keystream bit consumed, advance the scrambler |
| mod_o | output | 1 | Modulation output, 1 = carrier on |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock pulse at the end of a frame |
| now_o | output | 16 | Free-running tick count |
| last_end_o | output | 16 | Shared end-of-frame timestamp |

## Verification
The bench sends frames of every length from 0 to 32 back to back, plus oversized and poked frames. A design that counted the guard interval from the start strobe, or one tick off, would move the first gap away from `last_end_o`+330. The waveform is compared sample by sample against a bit train built from the data and a bench-side keystream model. An off-by-one segment counter, a swapped bit order or a missed or doubled keystream advance would show up as a shifted or wrong mark. A late start tests the path where the guard interval has already passed. A start pulse in the middle of a frame would, on a design that re-armed, corrupt the train or launch a second frame.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    PBM_IDLE,
    PBM_GAP,
    PBM_PAUSE,
    PBM_MARK,
    PBM_TAIL
  } pbm_state_e;

  function automatic int unsigned pbm_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pbm_timebase.sv
module pbm_timebase #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            stamp_i,
  output logic [TS_W-1:0] now_o,
  output logic [TS_W-1:0] now_next_o,
  output logic [TS_W-1:0] last_end_o
);

  logic [TS_W-1:0] now_q;
  logic [TS_W-1:0] now_d;
  logic [TS_W-1:0] stamp_q;
  logic [TS_W-1:0] stamp_d;

  always_comb begin
    now_d   = tick_i  ? now_q + TS_W'(1) : now_q;
    stamp_d = stamp_i ? now_d : stamp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
    end else if (tick_i) begin
      now_q <= now_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
    end else if (stamp_i) begin
      stamp_q <= stamp_d;
    end
  end

  assign now_o      = now_q;
  assign now_next_o = now_d;
  assign last_end_o = stamp_q;

endmodule

// File: rtl/pbm_seg_timer.sv
module pbm_seg_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | tick_i;
    if (clear_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = tick_i && (cnt_q == (limit_i - CNT_W'(1)));

endmodule

// File: rtl/pbm_bit_source.sv
module pbm_bit_source #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] frame_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                take_i,
  input  logic                ks_bit_i,
  output logic                tx_bit_o,
  output logic                empty_o
);

  localparam int unsigned LEFT_W  = $clog2(MAX_BITS + 1);
  localparam int unsigned LEN_TOP = (1 << LEN_W) - 1;

  logic [MAX_BITS-1:0] shreg_q;
  logic [MAX_BITS-1:0] shreg_d;
  logic [LEFT_W-1:0]   left_q;
  logic [LEFT_W-1:0]   left_d;
  logic [LEFT_W-1:0]   len_fit;
  logic                bit_q;
  logic                bit_d;
  logic                shift_en;

  generate
    if (LEN_TOP > MAX_BITS) begin : g_clamp
      always_comb begin
        if (int'(len_i) > int'(MAX_BITS)) begin
          len_fit = LEFT_W'(MAX_BITS);
        end else begin
          len_fit = LEFT_W'(len_i);
        end
      end
    end else begin : g_direct
      always_comb len_fit = LEFT_W'(len_i);
    end
  endgenerate

  always_comb begin
    shift_en = load_i | take_i;
    if (load_i) begin
      shreg_d = frame_i;
      left_d  = len_fit;
    end else begin
      shreg_d = shreg_q >> 1;
      left_d  = left_q - LEFT_W'(1);
    end
    bit_d = shreg_q[0] ^ ks_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (shift_en) begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (take_i) begin
      bit_q <= bit_d;
    end
  end

  assign tx_bit_o = bit_q;
  assign empty_o  = (left_q == '0);

endmodule

// File: rtl/pause_bit_modulator.sv
module pause_bit_modulator
  import pbm_pkg::*;
#(
  parameter int unsigned TS_W        = 16,
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned LEN_W       = 6,
  parameter int unsigned PAUSE_TICKS = 30,
  parameter int unsigned ONE_TICKS   = 150,
  parameter int unsigned ZERO_TICKS  = 90,
  parameter int unsigned FRAME_GAP   = 330
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] frame_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                ks_bit_i,
  input  logic                rx_end_i,
  output logic                ks_adv_o,
  output logic                mod_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [TS_W-1:0]     now_o,
  output logic [TS_W-1:0]     last_end_o
);

  localparam int unsigned SEG_MAX = pbm_max3(PAUSE_TICKS, ONE_TICKS, ZERO_TICKS);
  localparam int unsigned SEG_W   = $clog2(SEG_MAX + 1);
  localparam logic [SEG_W-1:0] LIM_PAUSE = SEG_W'(PAUSE_TICKS);
  localparam logic [SEG_W-1:0] LIM_ONE   = SEG_W'(ONE_TICKS - PAUSE_TICKS);
  localparam logic [SEG_W-1:0] LIM_ZERO  = SEG_W'(ZERO_TICKS - PAUSE_TICKS);
  localparam logic [TS_W-1:0]  GAP_TS    = TS_W'(FRAME_GAP);

  pbm_state_e       state_q;
  pbm_state_e       state_d;
  logic             mod_q;
  logic             mod_d;
  logic             done_q;
  logic             load;
  logic             take;
  logic             seg_clr;
  logic             finish;
  logic [SEG_W-1:0] seg_lim;
  logic             seg_exp;
  logic             tx_bit;
  logic             empty;
  logic             gap_ok;
  logic             stamp;
  logic [TS_W-1:0]  now_next;
  logic [TS_W-1:0]  since_end;

  assign stamp = finish | rx_end_i;

  pbm_timebase #(
    .TS_W(TS_W)
  ) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .stamp_i   (stamp),
    .now_o     (now_o),
    .now_next_o(now_next),
    .last_end_o(last_end_o)
  );

  pbm_seg_timer #(
    .CNT_W(SEG_W)
  ) u_seg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (seg_clr),
    .tick_i  (tick_i),
    .limit_i (seg_lim),
    .expire_o(seg_exp)
  );

  pbm_bit_source #(
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .frame_i (frame_i),
    .len_i   (len_i),
    .take_i  (take),
    .ks_bit_i(ks_bit_i),
    .tx_bit_o(tx_bit),
    .empty_o (empty)
  );

  always_comb begin
    since_end = now_next - last_end_o;
    gap_ok    = (since_end >= GAP_TS);
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    take    = 1'b0;
    seg_clr = 1'b0;
    finish  = 1'b0;
    seg_lim = LIM_PAUSE;
    unique case (state_q)
      PBM_IDLE: begin
        seg_clr = 1'b1;
        if (start_i) begin
          load    = 1'b1;
          state_d = PBM_GAP;
        end
      end
      PBM_GAP: begin
        seg_clr = 1'b1;
        if (gap_ok) begin
          if (empty) begin
            state_d = PBM_TAIL;
          end else begin
            take    = 1'b1;
            state_d = PBM_PAUSE;
          end
        end
      end
      PBM_PAUSE: begin
        seg_lim = LIM_PAUSE;
        if (seg_exp) begin
          seg_clr = 1'b1;
          state_d = PBM_MARK;
        end
      end
      PBM_MARK: begin
        seg_lim = tx_bit ? LIM_ONE : LIM_ZERO;
        if (seg_exp) begin
          seg_clr = 1'b1;
          if (empty) begin
            state_d = PBM_TAIL;
          end else begin
            take    = 1'b1;
            state_d = PBM_PAUSE;
          end
        end
      end
      PBM_TAIL: begin
        seg_lim = LIM_PAUSE;
        if (seg_exp) begin
          seg_clr = 1'b1;
          finish  = 1'b1;
          state_d = PBM_IDLE;
        end
      end
      default: begin
        state_d = PBM_IDLE;
      end
    endcase
    mod_d = !((state_d == PBM_PAUSE) || (state_d == PBM_TAIL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PBM_IDLE;
      mod_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mod_q   <= mod_d;
      done_q  <= finish;
    end
  end

  assign ks_adv_o = take;
  assign mod_o    = mod_q;
  assign busy_o   = (state_q != PBM_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
  parameter int unsigned TS_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            rx_end_i,
  input logic            ks_adv_o,
  input logic            mod_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [TS_W-1:0] now_o,
  input logic [TS_W-1:0] last_end_o
);

  AST_IDLE_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> mod_o); // R1

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(now_o)); // R2

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_i) && $past(rst_n)) |-> (now_o == $past(now_o) + TS_W'(1))); // R2

  AST_KS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |-> (busy_o && mod_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && mod_o)); // R9

  AST_STAMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (last_end_o == now_o)); // R11

  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(rx_end_i)) |-> $stable(last_end_o)); // R11

endmodule

bind pause_bit_modulator pbm_checker #(
  .TS_W(TS_W)
) u_pbm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .rx_end_i  (rx_end_i),
  .ks_adv_o  (ks_adv_o),
  .mod_o     (mod_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .now_o     (now_o),
  .last_end_o(last_end_o)
);

// File: tb/pause_bit_modulator_test.sv
`timescale 1ns/1ps
module pause_bit_modulator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] frame_i = '0;
  logic [5:0]  len_i = '0;
  logic        ks_bit_i = 1'b0;
  logic        rx_end_i = 1'b0;
  logic        ks_adv_o;
  logic        mod_o;
  logic        busy_o;
  logic        done_o;
  logic [15:0] now_o;
  logic [15:0] last_end_o;

  int          checks = 0;
  int          errors = 0;
  int          adv_cnt = 0;
  bit          ks_pend = 1'b0;
  bit          finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  pause_bit_modulator uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .frame_i   (frame_i),
    .len_i     (len_i),
    .ks_bit_i  (ks_bit_i),
    .rx_end_i  (rx_end_i),
    .ks_adv_o  (ks_adv_o),
    .mod_o     (mod_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .now_o     (now_o),
    .last_end_o(last_end_o)
  );

  function automatic logic [15:0] lfsr_next(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock; samples at the falling edge and serves the keystream port.
  task automatic step();
    @(negedge clk);
    if (ks_pend) begin
      lfsr     = lfsr_next(lfsr);
      ks_bit_i = lfsr[0];
      ks_pend  = 1'b0;
    end
    if (ks_adv_o) begin
      ks_pend = 1'b1;
      adv_cnt++;
    end
  endtask

  task automatic run_frame(input logic [31:0] data, input int len, input bit poke);
    logic [15:0] base;
    logic [15:0] st;
    logic [15:0] fall;
    logic [15:0] p;
    logic [31:0] sent;
    int n;
    int total;
    int d;
    int w;
    int bi;
    int off;
    int blen;
    int e_pause;
    int e_mark;
    int e_tail;
    int e_done;
    bit lvl;
    int phase;
    string lreq;

    n = (len > 32) ? 32 : len;
    p = lfsr;
    sent = '0;
    total = 30;
    for (int i = 0; i < n; i++) begin
      sent[i] = data[i] ^ p[0];
      p = lfsr_next(p);
      total += sent[i] ? 150 : 90;
    end
    base = last_end_o;
    st   = now_o;
    d    = int'(16'(st - base));
    fall = (d + 2 >= 330) ? st + 16'd2 : base + 16'd330;

    frame_i = data;
    len_i   = len[5:0];
    start_i = 1'b1;
    adv_cnt = 0;
    step();
    start_i = 1'b0;
    frame_i = ~data;
    len_i   = 6'd5;

    w = 0;
    while (mod_o && w < 1000) begin
      step();
      w++;
    end
    check(now_o == fall, "R3", "tick count at first gap", now_o, fall);

    e_pause = 0; e_mark = 0; e_tail = 0; e_done = 0;
    bi = 0; off = 0;
    for (int k = 0; k < total; k++) begin
      if (bi < n) begin
        blen  = sent[bi] ? 150 : 90;
        lvl   = (off >= 30);
        phase = (off < 30) ? 0 : 1;
        off++;
        if (off == blen) begin
          bi++;
          off = 0;
        end
      end else begin
        lvl   = 1'b0;
        phase = 2;
      end
      if (mod_o != lvl) begin
        if (phase == 0) e_pause++;
        else if (phase == 1) e_mark++;
        else e_tail++;
      end
      if (done_o) e_done++;
      if (poke && k == 40) begin
        start_i = 1'b1;
        frame_i = 32'hFFFF_FFFF;
        len_i   = 6'd32;
        step();
        start_i = 1'b0;
      end else begin
        step();
      end
    end

    check(e_pause == 0, "R4", "wrong samples in bit gaps", e_pause, 0);
    check(e_mark == 0, "R5/R6/R7", "wrong samples in carrier-on marks", e_mark, 0);
    check(e_tail == 0, "R8", "wrong samples in closing gap", e_tail, 0);
    check(mod_o == 1'b1, "R8", "carrier after closing gap", mod_o, 1);
    check(e_done == 0, "R9", "early done samples", e_done, 0);
    check(done_o == 1'b1, "R9", "done at frame end", done_o, 1);
    check(busy_o == 1'b0, "R9", "busy at frame end", busy_o, 0);
    check(last_end_o == now_o, "R11", "timestamp at frame end", last_end_o, now_o);
    lreq = (len == 6 || len == 7 || len == 23 || len > 32) ? "R12" : "R7";
    check(adv_cnt == n, lreq, "keystream advances", adv_cnt, n);
    step();
    check(done_o == 1'b0, "R9", "done width", done_o, 0);
    if (poke) begin
      step();
      step();
      check(busy_o == 1'b0 && mod_o == 1'b1, "R10", "no frame after ignored start",
            {busy_o, mod_o}, 2'b01);
    end
  endtask

  initial begin
    ks_bit_i = lfsr[0];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mod_o == 1'b1, "R1", "reset carrier", mod_o, 1);
    check(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
    check(done_o == 1'b0, "R1", "reset done", done_o, 0);
    check(now_o == 16'd0, "R1", "reset tick count", now_o, 0);
    check(last_end_o == 16'd0, "R1", "reset timestamp", last_end_o, 0);

    repeat (5) step();
    check(now_o == 16'd0, "R2", "count held without tick", now_o, 0);
    tick_i = 1'b1;
    repeat (5) step();
    check(now_o == 16'd5, "R2", "count with tick", now_o, 5);

    repeat (7) step();
    rx_end_i = 1'b1;
    step();
    rx_end_i = 1'b0;
    check(last_end_o == now_o, "R11", "receive end stamp", last_end_o, now_o);
    check(mod_o == 1'b1 && busy_o == 1'b0, "R1", "idle carrier", mod_o, 1);

    // R12: sweep every length back to back
    for (int len = 0; len <= 32; len++) begin
      run_frame(32'h9E37_79B9 * (len + 7), len, 1'b0);
    end
    run_frame(32'hFFFF_FFFF, 32, 1'b0);
    run_frame(32'h0000_0000, 23, 1'b1);
    run_frame(32'h0000_002D, 6, 1'b0);
    run_frame(32'h0000_0055, 7, 1'b0);
    run_frame(32'hC0DE_1234, 45, 1'b0);
    repeat (500) step();
    run_frame(32'h0000_3A5C, 14, 1'b0);
    rx_end_i = 1'b1;
    step();
    rx_end_i = 1'b0;
    check(last_end_o == now_o, "R11", "receive end after frame", last_end_o, now_o);
    run_frame(32'h0001_F00F, 17, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=190000 expected=fewer cycles");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule